// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block runs the setup-word protocol of a programmable interrupt controller. A host writes a short series of bytes over an 8-bit bus, qualified by chip select, one address line and an active-low write strobe. The block recognizes each write and stores the byte in the register that the sequence currently selects. It then publishes the resulting configuration as plain outputs: single or cascade operation, whether a fourth word follows, the interrupt vector base, a per-line cascade mask when the controller is a master, a three-bit identity when it is a slave, and a ready flag.

The sequence always begins with a start word, which has the address line low and data bit 4 high. A vector-base word follows with the address line high. A cascade word comes next only in cascade mode, and a mode word comes last only when the start word asked for it. A start word is honoured at any point and restarts the sequence.

A write is counted once, when the sampled strobe goes from high to low while chip select is high. The data byte is captured on that same rising clock edge, and the selection moves on to the next word at that moment. While ready is low, downstream interrupt logic must treat every request line as masked. All interfaces are plain control pins, because no data stream crosses this block.

Top module: `pic_init_seq`

## Requirements
- R1: After reset the block waits for a start word, ready is low, and all configuration outputs (single_mode, need_word4, vector_base, cascade_mask, slave_id, is_master, mode_word) are zero.
- R2: A write with cs high, addr_sel low and data bit 4 high is a start word. It is accepted in any state. It restarts the sequence, drives ready low, and sets single_mode from data bit 1 and need_word4 from data bit 0. The other configuration outputs keep their values.
- R3: After a start word, the next write with addr_sel high is always the vector-base word, and vector_base takes its full byte.
- R4: When single_mode is 1 the cascade word is skipped. If need_word4 is also 0, ready rises on the vector-base write.
- R5: In cascade mode, the write with addr_sel high that follows the vector-base word is the cascade word. If role_master is high on that write, cascade_mask takes data bits 7:0 (bit n set marks request line n as fed by a slave), is_master becomes 1 and slave_id becomes 0.
- R6: If role_master is low on the cascade word, slave_id takes data bits 2:0, data bits 7:3 are ignored, is_master becomes 0 and cascade_mask becomes 0.
- R7: When need_word4 is 1, the word after the last required earlier word is the mode word. mode_word takes its byte and ready rises on that write.
- R8: Writes made while cs is low have no effect on any output.
- R9: A strobe held low counts as exactly one write. Changes on the bus while the strobe stays low are not captured.
- R10: Once ready is high, writes with addr_sel high change nothing. A write with addr_sel low and data bit 4 low is never taken as a sequence word.
- R11: ready is low from a start word until the final required word is written. It rises only on a write with addr_sel high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; data captured on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| addr_sel | input | 1 | Address line: low for start word, high for the following words |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 8 | Write data bus |
| role_master | input | 1 | Master (high) or slave (low) role, sampled on the cascade word |
| single_mode | output | 1 | Single-controller operation, from start word bit 1 |
| need_word4 | output | 1 | Mode word required, from start word bit 0 |
| vector_base | output | 8 | Vector-base word |
| cascade_mask | output | 8 | Request lines fed by slaves (master only) |
| slave_id | output | 3 | Slave identity (slave only) |
| is_master | output | 1 | Registered role flag |
| mode_word | output | 8 | Mode word |
| ready | output | 1 | Sequence complete; interrupts may be accepted |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, eight request lines and a 3-bit identity. With these values every mask bit and every identity code can be reached through a single cascade word. The bench runs all four sequence shapes (single or cascade, with or without the mode word). It also restarts the sequence in the middle, and it checks that writes are ignored when chip select is off, when the strobe is held low, and after ready has risen.

// File: rtl/pic_init_pkg.sv
`timescale 1ns/1ps
package pic_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VEC  = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  // bit positions inside the start word
  localparam int START_KEY_BIT = 4;
  localparam int SINGLE_BIT    = 1;
  localparam int NEED4_BIT     = 0;
endpackage

// File: rtl/pic_wr_edge.sv
`timescale 1ns/1ps
module pic_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic wr_n,
  output logic wr_event
);
  logic wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n;
  end

  // one event per high-to-low strobe transition with chip select active
  assign wr_event = cs & wr_n_q & ~wr_n;
endmodule

// File: rtl/pic_init_fsm.sv
`timescale 1ns/1ps
module pic_init_fsm
  import pic_init_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_event,
  input  logic              addr_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic              single_q,
  input  logic              need4_q,
  output logic              ld_start,
  output logic              ld_vec,
  output logic              ld_casc,
  output logic              ld_mode,
  output logic              ready
);
  seq_state_t st, st_nxt;
  logic       follow_wr;

  assign follow_wr = wr_event & addr_sel;

  always_comb begin
    ld_start = wr_event & ~addr_sel & data_in[START_KEY_BIT];
    ld_vec   = 1'b0;
    ld_casc  = 1'b0;
    ld_mode  = 1'b0;
    st_nxt   = st;
    if (ld_start) begin
      st_nxt = ST_VEC;
    end else if (follow_wr) begin
      unique case (st)
        ST_VEC: begin
          ld_vec = 1'b1;
          if (!single_q)    st_nxt = ST_CASC;
          else if (need4_q) st_nxt = ST_MODE;
          else              st_nxt = ST_RUN;
        end
        ST_CASC: begin
          ld_casc = 1'b1;
          st_nxt  = need4_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          ld_mode = 1'b1;
          st_nxt  = ST_RUN;
        end
        default: st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign ready = (st == ST_RUN);
endmodule

// File: rtl/pic_cfg_regs.sv
`timescale 1ns/1ps
module pic_cfg_regs
  import pic_init_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINES  = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic              ld_vec,
  input  logic              ld_casc,
  input  logic              ld_mode,
  input  logic [DATA_W-1:0] data_in,
  input  logic              role_master,
  output logic              single_q,
  output logic              need4_q,
  output logic [DATA_W-1:0] vec_q,
  output logic [LINES-1:0]  mask_q,
  output logic [ID_W-1:0]   id_q,
  output logic              master_q,
  output logic [DATA_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (ld_start) begin
      single_q <= data_in[SINGLE_BIT];
      need4_q  <= data_in[NEED4_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (ld_vec) vec_q <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (ld_mode) mode_q <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      id_q     <= '0;
    end else if (ld_casc) begin
      master_q <= role_master;
      id_q     <= role_master ? '0 : data_in[ID_W-1:0];
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[i] <= 1'b0;
      else if (ld_casc) mask_q[i] <= role_master & data_in[i];
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
module pic_init_seq #(
  parameter int DATA_W = 8,
  parameter int LINES  = 8,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              addr_sel,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              role_master,
  output logic              single_mode,
  output logic              need_word4,
  output logic [DATA_W-1:0] vector_base,
  output logic [LINES-1:0]  cascade_mask,
  output logic [ID_W-1:0]   slave_id,
  output logic              is_master,
  output logic [DATA_W-1:0] mode_word,
  output logic              ready
);
  logic wr_event, ld_start, ld_vec, ld_casc, ld_mode;

  pic_wr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_n(wr_n), .wr_event(wr_event)
  );

  pic_init_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_event(wr_event), .addr_sel(addr_sel),
    .data_in(data_in), .single_q(single_mode), .need4_q(need_word4),
    .ld_start(ld_start), .ld_vec(ld_vec), .ld_casc(ld_casc),
    .ld_mode(ld_mode), .ready(ready)
  );

  pic_cfg_regs #(.DATA_W(DATA_W), .LINES(LINES), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_vec(ld_vec),
    .ld_casc(ld_casc), .ld_mode(ld_mode), .data_in(data_in),
    .role_master(role_master), .single_q(single_mode), .need4_q(need_word4),
    .vec_q(vector_base), .mask_q(cascade_mask), .id_q(slave_id),
    .master_q(is_master), .mode_q(mode_word)
  );
endmodule

// File: rtl/pic_init_seq_chk.sv
`timescale 1ns/1ps
module pic_init_seq_chk #(
  parameter int DATA_W = 8,
  parameter int LINES  = 8,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              addr_sel,
  input logic              wr_n,
  input logic [DATA_W-1:0] data_in,
  input logic              single_mode,
  input logic              need_word4,
  input logic [DATA_W-1:0] vector_base,
  input logic [LINES-1:0]  cascade_mask,
  input logic [ID_W-1:0]   slave_id,
  input logic              is_master,
  input logic [DATA_W-1:0] mode_word,
  input logic              ready
);
  logic prev_wr_n, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_wr_n <= 1'b1;
    else        prev_wr_n <= wr_n;
  end
  assign ev = cs & prev_wr_n & ~wr_n;

  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !addr_sel && data_in[4]) |=>
      (!ready && single_mode == $past(data_in[1]) && need_word4 == $past(data_in[0])));

  a_r8_deselect_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable({ready, single_mode, need_word4, vector_base, cascade_mask,
                     slave_id, is_master, mode_word}));

  a_r5_master_no_id: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (slave_id == '0));

  a_r6_slave_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (cascade_mask == '0));

  a_r11_ready_on_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ev && addr_sel));
endmodule

bind pic_init_seq pic_init_seq_chk #(.DATA_W(DATA_W), .LINES(LINES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .addr_sel(addr_sel), .wr_n(wr_n),
  .data_in(data_in), .single_mode(single_mode), .need_word4(need_word4),
  .vector_base(vector_base), .cascade_mask(cascade_mask), .slave_id(slave_id),
  .is_master(is_master), .mode_word(mode_word), .ready(ready)
);

// File: tb/pic_init_seq_test.sv
`timescale 1ns/1ps
module pic_init_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, addr_sel = 1'b0, wr_n = 1'b1, role_master = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic single_mode, need_word4, is_master, ready;
  logic [7:0] vector_base, cascade_mask, mode_word;
  logic [2:0] slave_id;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic rdy, sng, n4, mst;
    logic [7:0] vec, msk, mode;
    logic [2:0] id;
    int due;
    string tag;
  } exp_t;

  exp_t e;
  exp_t q[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pic_init_seq uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr_sel(addr_sel), .wr_n(wr_n),
    .data_in(data_in), .role_master(role_master), .single_mode(single_mode),
    .need_word4(need_word4), .vector_base(vector_base), .cascade_mask(cascade_mask),
    .slave_id(slave_id), .is_master(is_master), .mode_word(mode_word), .ready(ready)
  );

  // monitor: compare each expected snapshot in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (ready !== x.rdy || single_mode !== x.sng || need_word4 !== x.n4 ||
          vector_base !== x.vec || cascade_mask !== x.msk || slave_id !== x.id ||
          is_master !== x.mst || mode_word !== x.mode) begin
        errors++;
        $display("FAIL %s: got rdy=%b sng=%b n4=%b vec=%h msk=%h id=%0d mst=%b mode=%h exp rdy=%b sng=%b n4=%b vec=%h msk=%h id=%0d mst=%b mode=%h",
                 x.tag, ready, single_mode, need_word4, vector_base, cascade_mask,
                 slave_id, is_master, mode_word, x.rdy, x.sng, x.n4, x.vec,
                 x.msk, x.id, x.mst, x.mode);
      end
    end
  end

  task automatic push(input string tag, input int delay);
    e.due = cyc + delay;
    e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one complete write, expected state already placed in e
  task automatic wr(input logic c, input logic a, input logic [7:0] d,
                    input logic role, input string tag);
    @(negedge clk);
    cs = c; addr_sel = a; data_in = d; role_master = role; wr_n = 1'b0;
    push(tag, 1);
    @(negedge clk);
    wr_n = 1'b1; cs = 1'b0;
  endtask

  initial begin
    e = '{rdy:0, sng:0, n4:0, mst:0, vec:0, msk:0, mode:0, id:0, due:0, tag:""};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset state", 0);

    // cascade, master, with mode word
    e.sng = 0; e.n4 = 1; e.rdy = 0;
    wr(1, 0, 8'h11, 0, "R2 start word cascade+need4");
    e.vec = 8'h40;
    wr(1, 1, 8'h40, 0, "R3 vector base");
    e.msk = 8'h84; e.mst = 1; e.id = 0;
    wr(1, 1, 8'h84, 1, "R5 master cascade mask");
    e.mode = 8'h1D; e.rdy = 1;
    wr(1, 1, 8'h1D, 0, "R7 mode word sets ready");
    wr(1, 1, 8'h55, 0, "R10 follow write after ready ignored");
    wr(1, 0, 8'h05, 0, "R10 addr low bit4 low not a start word");
    wr(0, 0, 8'h13, 0, "R8 deselected start word ignored");

    // single, no mode word
    e.sng = 1; e.n4 = 0; e.rdy = 0;
    wr(1, 0, 8'h12, 0, "R11 start word drops ready");
    e.vec = 8'h88; e.rdy = 1;
    wr(1, 1, 8'h88, 0, "R4 single mode skips cascade word");

    // cascade, slave, no mode word
    e.sng = 0; e.n4 = 0; e.rdy = 0;
    wr(1, 0, 8'h10, 0, "R2 start word cascade");
    e.vec = 8'h20;
    wr(1, 1, 8'h20, 1, "R11 ready low awaiting cascade word");
    wr(0, 1, 8'hFF, 1, "R8 deselected cascade word ignored");
    e.id = 3'd5; e.msk = 8'h00; e.mst = 0; e.rdy = 1;
    wr(1, 1, 8'hFD, 0, "R6 slave id, high bits ignored");

    // held strobe counts once
    e.rdy = 0;
    @(negedge clk);
    cs = 1; addr_sel = 0; data_in = 8'h10; wr_n = 1'b0;
    push("R9 held strobe start word", 1);
    @(negedge clk);
    addr_sel = 1; data_in = 8'h99;
    repeat (2) @(negedge clk);
    push("R9 held strobe no second capture", 0);
    @(negedge clk);
    wr_n = 1'b1; cs = 1'b0;
    e.vec = 8'h99;
    wr(1, 1, 8'h99, 0, "R3 vector word after held strobe");

    // restart from cascade-wait, then single with mode word
    e.sng = 1; e.n4 = 1;
    wr(1, 0, 8'h13, 0, "R2 restart mid sequence");
    e.vec = 8'h30;
    wr(1, 1, 8'h30, 0, "R11 single awaiting mode word");
    e.mode = 8'h02; e.rdy = 1;
    wr(1, 1, 8'h02, 0, "R7 mode word after single vector");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule